// File: doc/BRIEF.md
# Time-Multiplexed Four-Lane FIR Engine

This block computes a finite impulse response filter of 1 to 256 taps from one cell of four signed 16x16 multiply-accumulate lanes. A filter of N taps is broken into P = floor((N+3)/4) groups of four taps. The cell is reused once per group for every input sample, and the group results are summed in a 40-bit two's complement accumulator, so no precision is lost. Samples are stored in a 256-entry circular history. Coefficients are held in an internal 256-entry store that is loaded through a simple write port.

A sample is taken on a rising clock edge while the active-low input strobe is low and the run control is high. Holding the active-low zero strobe low on the same edge stores a zero sample in place of the input. This is used to insert zeros for interpolation. The full-precision 40-bit sum is presented with a one-cycle active-low valid strobe. When N is at most 4, a new sample can be accepted on every clock. For longer filters, the sample rate must be at most one sample every P clocks. Normalisation to 16 bits is done outside this block.

Top module: `fir4_mux_engine`

## Requirements
- R1: For every accepted sample x(n), the result equals the sum over t = 0..N-1 of a(t)·x(n−t), computed in 40-bit two's complement. N is order_m1+1, a(t) is coefficient store entry t, and x(n−t) is the sample accepted t acceptances earlier. History entries that were never written read as zero after reset.
- R2: A sample accepted while smp_zero_n is low is stored and used as zero, whatever the value on smp_in. With smp_vld_n high, smp_zero_n has no effect.
- R3: When N ≤ 4, a sample can be accepted on every clock edge. Its result is valid in the cycle that follows the 4th rising edge after the capture edge.
- R4: When N > 4, the cell makes P = floor((N+3)/4) passes per sample. The result is valid in the cycle that follows the (4+P)th rising edge after the capture edge. For example, N = 10 gives 7 and N = 130 gives 37.
- R5: Coefficient store entries at index N and above never contribute to the result, even when they are nonzero.
- R6: res_vld_n is low for exactly one cycle per accepted sample, at the time given by R3 or R4, and is high at all other times.
- R7: While run is low, no sample is accepted and the history is left unchanged. After run returns high, results are computed over the history that was held before the stop.
- R8: buf_full goes high on the capture edge of the Nth sample accepted since run went high. It is low while run is low.
- R9: When N > 4, a strobe that arrives while passes of the previous sample are still being issued is ignored. It does not enter the history and it produces no result.
- R10: The longest filter, N = 256 (order_m1 = 255, P = 64), is computed correctly with a latency of 68 cycles.
- R11: After reset, res_vld_n is high, buf_full is low, res_out is zero and every history entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High enables sample acceptance |
| order_m1 | input | 8 | Number of taps minus one |
| coef_we | input | 1 | Coefficient store write enable |
| coef_idx | input | 8 | Coefficient store write index (tap number) |
| coef_val | input | 16 | Signed coefficient to write |
| smp_in | input | 16 | Signed input sample |
| smp_vld_n | input | 1 | Input sample strobe, active low |
| smp_zero_n | input | 1 | Store a zero sample instead of smp_in, active low |
| res_out | output | 40 | Signed full-precision filter result |
| res_vld_n | output | 1 | Result valid strobe, active low, one cycle |
| buf_full | output | 1 | N samples accepted since run went high |

## Verification
Two pairs of events can fall in the same cycle. The first pair is acceptance of a new sample and issue of the final pass of the previous one. The second is the accumulator clearing for a new sample's first group and the result of the previous sample being moved to the output. In single-tap-group mode these collide on every clock, and the bench provokes this with back-to-back strobes. In sequential mode the bench spaces samples exactly P clocks apart, so each capture lands on the edge after the last pass issue. It also sends a strobe one clock into the passes, which must be rejected. Each result is judged by a bench model that keeps its own history and coefficient copy and tracks the cycle in which res_vld_n is due. Any early, late, extra or missing pulse, or a wrong 40-bit value, is reported.

// File: rtl/fir4_pkg.sv
// Package fir4_pkg
// Shared defaults and helpers for the four-lane FIR engine.
// Assumes the lane count and history depth are powers of two.
package fir4_pkg;
    localparam int SMP_W_DEF   = 16;
    localparam int ACC_W_DEF   = 40;
    localparam int DEPTH_DEF   = 256;
    localparam int LANES_DEF   = 4;

    // Index of the final pass for a given (taps-1); equals floor((N+3)/LANES)-1.
    function automatic int last_pass_of(input int order_m1, input int lanes);
        return order_m1 / lanes;
    endfunction
endpackage

// File: rtl/fir4_hist_ram.sv
// Module fir4_hist_ram
// Circular sample history with one write port and LANES combinational read
// ports. The write pointer always names the newest entry. A write stores at
// pointer+1 and advances the pointer. Reset clears every entry so that taps
// reaching before the first sample read as zero.
// Assumes DEPTH is a power of two.
module fir4_hist_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    output logic [IW-1:0]              newest,
    input  logic [LANES-1:0][IW-1:0]   rd_addr,
    output logic [LANES-1:0][DW-1:0]   rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] next_slot;

    assign next_slot = newest + IW'(1);

    // Store the accepted sample and advance the newest-entry pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newest <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[next_slot] <= wr_data;
            newest         <= next_slot;
        end
    end

    // One asynchronous read per lane.
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_rd
            assign rd_data[k] = mem[rd_addr[k]];
        end
    endgenerate
endmodule

// File: rtl/fir4_coef_ram.sv
// Module fir4_coef_ram
// Coefficient store indexed by tap number. It has one write port and LANES
// combinational read ports. Reset clears the store.
// Assumes writes are not made while results depend on the entry being written.
module fir4_coef_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic [LANES-1:0][IW-1:0]   rd_idx,
    output logic [LANES-1:0][DW-1:0]   rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Write one coefficient per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // One asynchronous read per lane.
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_rd
            assign rd_data[k] = mem[rd_idx[k]];
        end
    endgenerate
endmodule

// File: rtl/fir4_seq.sv
// Module fir4_seq
// Sample acceptance and pass sequencing. A strobe is taken only while run is
// high and the previous sample has no passes left to issue. Pass 0 is issued
// on the capture edge, and the following passes on the following edges, up to
// pass order_m1/LANES. It also counts the acceptances since run went high, to
// drive the buffer-full flag.
// Assumes order_m1 is held stable while samples are in flight.
module fir4_seq #(
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(LANES),
    localparam int PW   = IW - LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [IW-1:0] order_m1,
    input  logic          smp_vld_n,
    output logic          accept,
    output logic          iss_vld,
    output logic [PW-1:0] iss_pass,
    output logic          iss_first,
    output logic          iss_last,
    output logic          buf_full
);
    logic [PW-1:0] last_pass;
    logic          busy;
    logic [IW:0]   seen_cnt;
    logic [IW:0]   taps;

    assign last_pass = order_m1[IW-1:LW];
    assign busy      = iss_vld && (iss_pass != last_pass);
    assign accept    = run && !smp_vld_n && !busy;
    assign iss_first = (iss_pass == '0);
    assign iss_last  = (iss_pass == last_pass);
    assign taps      = {1'b0, order_m1} + (IW+1)'(1);
    assign buf_full  = (seen_cnt >= taps);

    // Start pass 0 on a capture, step through the passes, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_vld  <= 1'b0;
            iss_pass <= '0;
        end else if (accept) begin
            iss_vld  <= 1'b1;
            iss_pass <= '0;
        end else if (busy) begin
            iss_pass <= iss_pass + PW'(1);
        end else begin
            iss_vld  <= 1'b0;
        end
    end

    // Count acceptances since run went high, saturating at N.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            seen_cnt <= '0;
        end else if (accept && !buf_full) begin
            seen_cnt <= seen_cnt + (IW+1)'(1);
        end
    end

    AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> (iss_pass <= last_pass)); // R4
    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !buf_full); // R8
endmodule

// File: rtl/fir4_mac_cell.sv
// Module fir4_mac_cell
// The four-lane multiply-accumulate datapath, pipelined as:
// product register -> lane-sum register -> 40-bit accumulator -> output
// register -> optional extra output register. The accumulator is loaded with
// the lane sum on the first pass of a sample and adds to it on later passes.
// The extra output stage is selected when more than one pass is needed, which
// gives a latency of 4 cycles in single-group mode and 4+P cycles otherwise.
// Assumes the lane enables, coefficients and samples are aligned with iss_vld.
module fir4_mac_cell #(
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter int LANES = 4,
    localparam int PRW  = 2 * DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      single,
    input  logic                      iss_vld,
    input  logic                      iss_first,
    input  logic                      iss_last,
    input  logic [LANES-1:0]          lane_on,
    input  logic [LANES-1:0][DW-1:0]  coef_rd,
    input  logic [LANES-1:0][DW-1:0]  smp_rd,
    output logic [AW-1:0]             res,
    output logic                      res_vld_n
);
    logic signed [PRW-1:0] prod_q [LANES];
    logic                  b_vld, b_first, b_last;
    logic signed [AW-1:0]  lane_sum;
    logic signed [AW-1:0]  sum_q;
    logic                  c_vld, c_first, c_last;
    logic signed [AW-1:0]  acc_q;
    logic                  d_done;
    logic [AW-1:0]         out1_q, out2_q;
    logic                  v1_q, v2_q;

    // Sign-extend a lane product to accumulator width.
    function automatic logic signed [AW-1:0] widen(input logic signed [PRW-1:0] p);
        return {{(AW-PRW){p[PRW-1]}}, p};
    endfunction

    // Per-lane multiply, with padded taps forced to zero.
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic signed [PRW-1:0] mul;
            assign mul = $signed(coef_rd[k]) * $signed(smp_rd[k]);
            // Register the lane product for this pass.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prod_q[k] <= '0;
                end else begin
                    prod_q[k] <= lane_on[k] ? mul : '0;
                end
            end
        end
    endgenerate

    // Carry the pass markers alongside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_vld   <= 1'b0;
            b_first <= 1'b0;
            b_last  <= 1'b0;
        end else begin
            b_vld   <= iss_vld;
            b_first <= iss_first;
            b_last  <= iss_last;
        end
    end

    // Add the registered lane products at full width.
    always_comb begin
        lane_sum = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_sum = lane_sum + widen(prod_q[k]);
        end
    end

    // Register the lane sum and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            c_vld   <= 1'b0;
            c_first <= 1'b0;
            c_last  <= 1'b0;
        end else begin
            sum_q   <= lane_sum;
            c_vld   <= b_vld;
            c_first <= b_first;
            c_last  <= b_last;
        end
    end

    // Load on the first pass of a sample, add on later passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            d_done <= 1'b0;
        end else begin
            d_done <= c_vld && c_last;
            if (c_vld) begin
                acc_q <= c_first ? sum_q : acc_q + sum_q;
            end
        end
    end

    // Output stage one: capture the finished sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out1_q <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= d_done;
            if (d_done) begin
                out1_q <= acc_q;
            end
        end
    end

    // Output stage two: extra cycle used only in sequential mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out2_q <= '0;
            v2_q   <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                out2_q <= out1_q;
            end
        end
    end

    assign res       = single ? out1_q : out2_q;
    assign res_vld_n = single ? !v1_q : !v2_q;

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !lane_on[LANES-1]) |=> (prod_q[LANES-1] == '0)); // R5
    AST_SEQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!single && $stable(single) && !res_vld_n) |=> res_vld_n); // R6
    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (c_vld && c_first) |=> (acc_q == $past(sum_q))); // R1
endmodule

// File: rtl/fir4_mux_engine.sv
// Module fir4_mux_engine
// Top level of the time-multiplexed FIR engine. It ties together the
// sequencer, the sample history, the coefficient store and the MAC cell. For
// pass j, lane k serves tap t = LANES*j + k: it reads coefficient t and the
// sample t acceptances older than the newest one, and it is disabled when
// t exceeds order_m1.
// Assumes LANES and DEPTH are powers of two and that order_m1 and the
// coefficients are changed only while no sample is in flight.
module fir4_mux_engine #(
    parameter int DW    = fir4_pkg::SMP_W_DEF,
    parameter int AW    = fir4_pkg::ACC_W_DEF,
    parameter int DEPTH = fir4_pkg::DEPTH_DEF,
    parameter int LANES = fir4_pkg::LANES_DEF,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(LANES),
    localparam int PW   = IW - LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [IW-1:0] order_m1,
    input  logic          coef_we,
    input  logic [IW-1:0] coef_idx,
    input  logic [DW-1:0] coef_val,
    input  logic [DW-1:0] smp_in,
    input  logic          smp_vld_n,
    input  logic          smp_zero_n,
    output logic [AW-1:0] res_out,
    output logic          res_vld_n,
    output logic          buf_full
);
    logic                     accept;
    logic                     iss_vld, iss_first, iss_last;
    logic [PW-1:0]            iss_pass;
    logic [IW-1:0]            newest;
    logic [DW-1:0]            wr_data;
    logic [LANES-1:0][IW-1:0] tap;
    logic [LANES-1:0][IW-1:0] h_addr;
    logic [LANES-1:0]         lane_on;
    logic [LANES-1:0][DW-1:0] coef_rd;
    logic [LANES-1:0][DW-1:0] smp_rd;
    logic                     single;

    assign single  = (order_m1 < IW'(LANES));
    assign wr_data = smp_zero_n ? smp_in : '0;

    fir4_seq #(.DEPTH(DEPTH), .LANES(LANES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .order_m1  (order_m1),
        .smp_vld_n (smp_vld_n),
        .accept    (accept),
        .iss_vld   (iss_vld),
        .iss_pass  (iss_pass),
        .iss_first (iss_first),
        .iss_last  (iss_last),
        .buf_full  (buf_full)
    );

    // Tap number, history address and pad mask for each lane.
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_addr
            localparam logic [LW-1:0] KK = LW'(k);
            assign tap[k]     = {iss_pass, KK};
            assign lane_on[k] = (tap[k] <= order_m1);
            assign h_addr[k]  = newest - tap[k];
        end
    endgenerate

    fir4_hist_ram #(.DW(DW), .DEPTH(DEPTH), .LANES(LANES)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data (wr_data),
        .newest  (newest),
        .rd_addr (h_addr),
        .rd_data (smp_rd)
    );

    fir4_coef_ram #(.DW(DW), .DEPTH(DEPTH), .LANES(LANES)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_idx  (coef_idx),
        .wr_data (coef_val),
        .rd_idx  (tap),
        .rd_data (coef_rd)
    );

    fir4_mac_cell #(.DW(DW), .AW(AW), .LANES(LANES)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .single    (single),
        .iss_vld   (iss_vld),
        .iss_first (iss_first),
        .iss_last  (iss_last),
        .lane_on   (lane_on),
        .coef_rd   (coef_rd),
        .smp_rd    (smp_rd),
        .res       (res_out),
        .res_vld_n (res_vld_n)
    );

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(newest)); // R7
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_last) |=> $stable(newest)); // R9
endmodule

// File: tb/fir4_mux_engine_test.sv
// Bench for fir4_mux_engine. Random samples and coefficients from a fixed
// seed, plus directed corner cases. A bench model computes each expected
// result and the cycle in which it is due.
module fir4_mux_engine_test;
    logic        clk = 1'b0;
    logic        rst_n, run, coef_we, smp_vld_n, smp_zero_n;
    logic [7:0]  order_m1, coef_idx;
    logic [15:0] coef_val, smp_in;
    logic [39:0] res_out;
    logic        res_vld_n, buf_full;

    always #2.5 clk = ~clk;

    fir4_mux_engine uut (
        .clk(clk), .rst_n(rst_n), .run(run), .order_m1(order_m1),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
        .smp_in(smp_in), .smp_vld_n(smp_vld_n), .smp_zero_n(smp_zero_n),
        .res_out(res_out), .res_vld_n(res_vld_n), .buf_full(buf_full)
    );

    int     cyc = 0;
    int     total = 0, bad = 0, unexp = 0;
    int     hist [256];
    int     coef [256];
    int     wp = 0;
    longint q_val [$];
    int     q_due [$];
    string  q_tag [$];
    longint got;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected result over the model history (R1, R5: only taps below N).
    function automatic longint model_result();
        longint s = 0;
        int n = int'(order_m1) + 1;
        for (int t = 0; t < n; t++) begin
            s += longint'(coef[t]) * longint'(hist[(wp - t) & 255]);
        end
        return s;
    endfunction

    function automatic int latency();
        int n = int'(order_m1) + 1;
        return (n <= 4) ? 4 : 4 + (n + 3) / 4;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Result monitor: value and timing of every pulse (R1, R3, R4, R6).
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                total++;
                got = $signed(res_out);
                if (res_vld_n !== 1'b0 || got != q_val[0]) begin
                    bad++;
                    $display("FAIL %s R1: vld_n=%0b actual=%0d expected=%0d at cycle %0d",
                             q_tag[0], res_vld_n, got, q_val[0], cyc);
                end
                void'(q_val.pop_front());
                void'(q_due.pop_front());
                void'(q_tag.pop_front());
            end else if (res_vld_n === 1'b0) begin
                total++;
                bad++;
                unexp++;
                $display("FAIL R6: unexpected pulse actual=%0d expected=none at cycle %0d",
                         $signed(res_out), cyc);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcoef(input int i, input logic [15:0] v);
        coef_we = 1'b1; coef_idx = 8'(i); coef_val = v;
        coef[i] = int'($signed(v));
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    // Accepted sample: update the model and schedule the expected result.
    task automatic send(input logic [15:0] x, input bit z, input string tag);
        smp_in = x; smp_zero_n = ~z; smp_vld_n = 1'b0;
        wp = (wp + 1) & 255;
        hist[wp] = z ? 0 : int'($signed(x));
        q_val.push_back(model_result());
        q_due.push_back(cyc + 1 + latency());
        q_tag.push_back(tag);
        @(negedge clk);
        smp_vld_n = 1'b1; smp_zero_n = 1'b1;
    endtask

    // Strobe that the design must ignore (R7 stopped, R9 busy).
    task automatic send_dropped(input logic [15:0] x);
        smp_in = x; smp_vld_n = 1'b0;
        @(negedge clk);
        smp_vld_n = 1'b1;
    endtask

    initial begin
        int u0;
        int p;
        void'($urandom(32'd2024));
        rst_n = 1'b0; run = 1'b0; coef_we = 1'b0; smp_vld_n = 1'b1;
        smp_zero_n = 1'b1; order_m1 = 8'd3; coef_idx = '0; coef_val = '0;
        smp_in = '0;
        for (int i = 0; i < 256; i++) hist[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 res_vld_n", longint'(res_vld_n), 1);
        chk("R11 buf_full", longint'(buf_full), 0);
        chk("R11 res_out", longint'(res_out), 0);

        // Every entry gets a random value; entries at index N and up must not count (R5).
        for (int i = 0; i < 256; i++) wcoef(i, 16'($urandom));

        // Single mode, N=4: buffer-full edge, then back-to-back traffic (R3, R8, R11 zeros).
        order_m1 = 8'd3; run = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) send(16'($urandom), 1'b0, "R3");
        chk("R8 buf_full after 3 of 4", longint'(buf_full), 0);
        send(16'($urandom), 1'b0, "R3");
        chk("R8 buf_full after 4 of 4", longint'(buf_full), 1);
        send(16'h7fff, 1'b0, "R3");
        send(16'h8000, 1'b0, "R3");
        send(16'h1234, 1'b1, "R2");
        for (int i = 0; i < 40; i++) begin
            int r = int'($urandom % 8);
            if (r == 0) send(16'($urandom), 1'b1, "R2");
            else if (r == 1) begin
                smp_zero_n = 1'b0;
                @(negedge clk);
                smp_zero_n = 1'b1;
            end else send(16'($urandom), 1'b0, "R3");
        end
        idle(10);

        // Stop: flag drops, strobes are ignored, history is retained (R7, R8).
        run = 1'b0;
        @(negedge clk);
        chk("R8 buf_full while stopped", longint'(buf_full), 0);
        u0 = unexp;
        for (int i = 0; i < 5; i++) send_dropped(16'($urandom));
        idle(10);
        chk("R7 no pulse while stopped", longint'(unexp), longint'(u0));
        run = 1'b1;
        for (int i = 0; i < 6; i++) send(16'($urandom), 1'b0, "R7");
        idle(10);

        // Sequential mode, N=10, P=3: spacing P, busy strobes dropped (R4, R5, R9).
        run = 1'b0; order_m1 = 8'd9; idle(2); run = 1'b1;
        p = 3;
        for (int i = 0; i < 12; i++) begin
            send(16'($urandom), ($urandom % 6) == 0, "R4");
            if (i % 3 == 1) begin
                send_dropped(16'($urandom));
                idle(p - 2);
            end else idle(p - 1 + int'($urandom % 2));
        end
        idle(20);

        // N=130, P=33, latency 37 (R4).
        run = 1'b0; order_m1 = 8'd129; idle(2); run = 1'b1;
        for (int i = 0; i < 6; i++) begin
            send(16'($urandom), 1'b0, "R4");
            idle(32 + int'($urandom % 3));
        end
        idle(50);

        // N=256, P=64, latency 68 (R10).
        run = 1'b0; order_m1 = 8'd255; idle(2); run = 1'b1;
        for (int i = 0; i < 5; i++) begin
            send(16'($urandom), 1'b0, "R10");
            idle(63 + int'($urandom % 2));
        end
        idle(90);
        chk("R6 all results delivered", longint'(q_due.size()), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule